// File: doc/BRIEF.md
# Context-Tagged Multi-Page-Size Translation Cache

This block is a fully associative translation cache that turns a 44-bit virtual address into a 41-bit physical address. Each resident translation carries a virtual page number, a 13-bit address-space context number, its own page size (8 KB, 64 KB, 512 KB or 4 MB), a physical page number, a writable flag, a privileged-only flag and a lock flag. Because the context is part of the tag, translations that belong to many address spaces stay resident together, and a context switch needs no flush.

A lookup presents a virtual address and a two-bit address-space class. The class chooses the context used for matching: the primary context input, the secondary context input, or context zero for nucleus accesses. The result comes back registered one cycle later. A software miss handler loads one complete entry per command, either into a named slot or into a slot picked by a round-robin pointer that passes over locked entries. A demap command invalidates every entry of one context.

Maintenance commands run through a small state machine. ST_IDLE moves to ST_LOAD when a write is requested, and to ST_DEMAP when only a demap is requested. ST_LOAD and ST_DEMAP each last one cycle, and at the end of that cycle the storage is updated. From ST_LOAD or ST_DEMAP the machine goes straight to the next requested command's state, or back to ST_IDLE if nothing is requested.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid and `res_vld` is 0, so the first lookup misses.
- R2: For every cycle with `lk_vld` high, `res_vld` is high exactly one cycle later. `res_vld` is never high otherwise.
- R3: An entry with page size code 0 (8 KB) hits when virtual address bits 43:13 equal its page number. The result is its physical page number on bits 40:13 and the lookup address bits 12:0 below that.
- R4: Page size codes 1, 2 and 3 (64 KB, 512 KB, 4 MB) ignore the lowest 3, 6 or 9 bits of the stored page numbers in the tag compare. In the result, those physical bits are taken from the lookup address.
- R5: A hit also requires the entry context to equal the lookup context. Two entries that differ only in context both stay resident, and each serves its own context.
- R6: Address-space class 0 matches against `pri_ctx`, class 1 against `sec_ctx`, and classes 2 and 3 (nucleus) against context 0.
- R7: A hit returns the entry's writable and privileged flags. A miss returns a zero address and both flags at 0.
- R8: A write with `wr_slot_vld` high replaces the entry in slot `wr_slot`, whatever it held, and leaves the round-robin pointer unchanged.
- R9: A write with `wr_slot_vld` low goes to the first slot, searching upward with wrap from the round-robin pointer, that is not both valid and locked. The pointer then moves to the slot after it.
- R10: If every entry is valid and locked, a write with `wr_slot_vld` low is dropped, and existing entries are unchanged.
- R11: A demap invalidates every valid entry whose context equals `dm_ctx`, including locked ones. Entries of other contexts are untouched.
- R12: A command requested in cycle N is applied at the end of cycle N+1. A lookup presented in cycle N+1 sees the contents from before that command.
- R13: If `wr_en` and `dm_en` are high in the same cycle, the write is performed and the demap is ignored.
- R14: When several entries hit, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request |
| lk_va | input | 44 | Lookup virtual address |
| lk_asel | input | 2 | Address-space class: 0 primary, 1 secondary, 2/3 nucleus |
| pri_ctx | input | 13 | Primary context number |
| sec_ctx | input | 13 | Secondary context number |
| wr_en | input | 1 | Entry write request |
| wr_slot_vld | input | 1 | Use `wr_slot` instead of the round-robin pointer |
| wr_slot | input | 6 | Explicit target slot |
| wr_vpn | input | 31 | Virtual page number (address bits 43:13) |
| wr_ctx | input | 13 | Context of the new entry |
| wr_ppn | input | 28 | Physical page number (address bits 40:13) |
| wr_size | input | 2 | Page size code 0..3 = 8 KB, 64 KB, 512 KB, 4 MB |
| wr_writable | input | 1 | Writable flag of the new entry |
| wr_priv | input | 1 | Privileged-only flag of the new entry |
| wr_lock | input | 1 | Lock flag, which keeps the entry out of round-robin replacement |
| dm_en | input | 1 | Demap-by-context request |
| dm_ctx | input | 13 | Context to demap |
| res_vld | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_pa | output | 41 | Translated physical address |
| res_writable | output | 1 | Writable flag of the hitting entry |
| res_priv | output | 1 | Privileged flag of the hitting entry |

## Verification
A lookup and a maintenance command can fall in the same cycle. In the cycle where a demap or a write is applied, the registered lookup still reads the old storage. The bench provokes this by issuing a lookup in the cycle right after a demap request, and again right after a write request. It expects the pre-command result in that cycle and the post-command result one cycle later. A write and a demap requested in the same cycle are also provoked. The write is judged to have happened and the demap to have been dropped by looking up entries of both afterwards.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam int VA_W    = 44;
    localparam int PA_W    = 41;
    localparam int CTX_W   = 13;
    localparam int BASE_SH = 13;
    localparam int SZ_STEP = 3;
    localparam int VPN_W   = VA_W - BASE_SH;
    localparam int PPN_W   = PA_W - BASE_SH;

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        AS_PRIMARY   = 2'd0,
        AS_SECONDARY = 2'd1,
        AS_NUCLEUS   = 2'd2,
        AS_NUCLEUS_X = 2'd3
    } as_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DEMAP = 2'd2
    } cmd_st_e;

    typedef struct packed {
        logic             vld;
        logic             lock;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        pg_size_e         size;
        logic             wr;
        logic             priv;
    } tlb_ent_t;

    // Bits of a virtual page number that take part in the tag compare.
    function automatic logic [VPN_W-1:0] vpn_keep(pg_size_e s);
        return {VPN_W{1'b1}} << (SZ_STEP * int'(s));
    endfunction

    // Bits of a physical page number taken from the entry, not the address.
    function automatic logic [PPN_W-1:0] ppn_keep(pg_size_e s);
        return {PPN_W{1'b1}} << (SZ_STEP * int'(s));
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  tlb_ent_t                  wdata,
    input  logic                      clr_en,
    input  logic [CTX_W-1:0]          clr_ctx,
    input  logic [VPN_W-1:0]          look_vpn,
    input  logic [CTX_W-1:0]          look_ctx,
    output tlb_ent_t [ENTRIES-1:0]    ents_o,
    output logic     [ENTRIES-1:0]    hit_vec,
    output logic     [ENTRIES-1:0]    lock_eff
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_ent_t e_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_q <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                e_q <= wdata;
            end else if (clr_en && e_q.vld && (e_q.ctx == clr_ctx)) begin
                e_q.vld <= 1'b0;
            end
        end

        assign ents_o[g]   = e_q;
        assign lock_eff[g] = e_q.vld & e_q.lock;
        assign hit_vec[g]  = e_q.vld
                           && (e_q.ctx == look_ctx)
                           && (((e_q.vpn ^ look_vpn) & vpn_keep(e_q.size)) == '0);
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] busy,
    input  logic               adv,
    output logic [IDX_W-1:0]   vic_idx,
    output logic               vic_ok
);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        vic_ok  = 1'b0;
        vic_idx = ptr_q;
        for (int i = 0; i < ENTRIES; i++) begin
            logic [IDX_W-1:0] cand;
            cand = ptr_q + IDX_W'(i);
            if (!vic_ok && !busy[cand]) begin
                vic_ok  = 1'b1;
                vic_idx = cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv && vic_ok) begin
            ptr_q <= vic_idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_vld,
    input  logic [43:0]      lk_va,
    input  logic [1:0]       lk_asel,
    input  logic [12:0]      pri_ctx,
    input  logic [12:0]      sec_ctx,
    input  logic             wr_en,
    input  logic             wr_slot_vld,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [30:0]      wr_vpn,
    input  logic [12:0]      wr_ctx,
    input  logic [27:0]      wr_ppn,
    input  logic [1:0]       wr_size,
    input  logic             wr_writable,
    input  logic             wr_priv,
    input  logic             wr_lock,
    input  logic             dm_en,
    input  logic [12:0]      dm_ctx,
    output logic             res_vld,
    output logic             res_hit,
    output logic [40:0]      res_pa,
    output logic             res_writable,
    output logic             res_priv
);

    cmd_st_e state_q, state_d;

    logic [VPN_W-1:0] cmd_vpn;
    logic [PPN_W-1:0] cmd_ppn;
    logic [CTX_W-1:0] cmd_ctx;
    pg_size_e         cmd_size;
    logic             cmd_wr, cmd_priv, cmd_lock;
    logic             cmd_slot_vld;
    logic [IDX_W-1:0] cmd_slot;

    logic             cam_we, cam_clr, vic_adv, vic_ok;
    logic [IDX_W-1:0] cam_widx, vic_idx;
    tlb_ent_t         cam_wdata;
    logic [CTX_W-1:0] look_ctx;

    tlb_ent_t [ENTRIES-1:0] ents;
    logic     [ENTRIES-1:0] hit_vec, lock_eff, vld_vec;

    tlb_ent_t         sel_ent;
    logic             any_hit;
    logic [PA_W-1:0]  pa_calc;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: a write request outranks a demap request.
    always_comb begin
        unique case ({wr_en, dm_en})
            2'b10, 2'b11: state_d = ST_LOAD;
            2'b01:        state_d = ST_DEMAP;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Command capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_vpn      <= '0;
            cmd_ppn      <= '0;
            cmd_ctx      <= '0;
            cmd_size     <= PG_8K;
            cmd_wr       <= 1'b0;
            cmd_priv     <= 1'b0;
            cmd_lock     <= 1'b0;
            cmd_slot_vld <= 1'b0;
            cmd_slot     <= '0;
        end else if (wr_en) begin
            cmd_vpn      <= wr_vpn;
            cmd_ppn      <= wr_ppn;
            cmd_ctx      <= wr_ctx;
            cmd_size     <= pg_size_e'(wr_size);
            cmd_wr       <= wr_writable;
            cmd_priv     <= wr_priv;
            cmd_lock     <= wr_lock;
            cmd_slot_vld <= wr_slot_vld;
            cmd_slot     <= wr_slot;
        end else if (dm_en) begin
            cmd_ctx      <= dm_ctx;
        end
    end

    // Per-state actions on the storage.
    always_comb begin
        cam_we   = 1'b0;
        cam_clr  = 1'b0;
        vic_adv  = 1'b0;
        cam_widx = cmd_slot_vld ? cmd_slot : vic_idx;
        unique case (state_q)
            ST_LOAD: begin
                cam_we  = cmd_slot_vld | vic_ok;
                vic_adv = ~cmd_slot_vld;
            end
            ST_DEMAP: cam_clr = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        cam_wdata      = '0;
        cam_wdata.vld  = 1'b1;
        cam_wdata.lock = cmd_lock;
        cam_wdata.ctx  = cmd_ctx;
        cam_wdata.vpn  = cmd_vpn;
        cam_wdata.ppn  = cmd_ppn;
        cam_wdata.size = cmd_size;
        cam_wdata.wr   = cmd_wr;
        cam_wdata.priv = cmd_priv;
    end

    // Context chosen by the access class.
    always_comb begin
        unique case (as_sel_e'(lk_asel))
            AS_PRIMARY:   look_ctx = pri_ctx;
            AS_SECONDARY: look_ctx = sec_ctx;
            default:      look_ctx = '0;
        endcase
    end

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cam_we),
        .widx     (cam_widx),
        .wdata    (cam_wdata),
        .clr_en   (cam_clr),
        .clr_ctx  (cmd_ctx),
        .look_vpn (lk_va[VA_W-1:BASE_SH]),
        .look_ctx (look_ctx),
        .ents_o   (ents),
        .hit_vec  (hit_vec),
        .lock_eff (lock_eff)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (lock_eff),
        .adv     (vic_adv),
        .vic_idx (vic_idx),
        .vic_ok  (vic_ok)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign vld_vec[g] = ents[g].vld;
    end

    // Lowest-numbered hitting slot wins.
    always_comb begin
        any_hit = 1'b0;
        sel_ent = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                sel_ent = ents[i];
            end
        end
        pa_calc = {(sel_ent.ppn & ppn_keep(sel_ent.size))
                   | (lk_va[PA_W-1:BASE_SH] & ~ppn_keep(sel_ent.size)),
                   lk_va[BASE_SH-1:0]};
    end

    // Registered lookup result.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld      <= 1'b0;
            res_hit      <= 1'b0;
            res_pa       <= '0;
            res_writable <= 1'b0;
            res_priv     <= 1'b0;
        end else begin
            res_vld <= lk_vld;
            if (lk_vld && any_hit) begin
                res_hit      <= 1'b1;
                res_pa       <= pa_calc;
                res_writable <= sel_ent.wr;
                res_priv     <= sel_ent.priv;
            end else begin
                res_hit      <= 1'b0;
                res_pa       <= '0;
                res_writable <= 1'b0;
                res_priv     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_vld,
    input logic               wr_en,
    input logic               dm_en,
    input logic               res_vld,
    input logic               res_hit,
    input logic [40:0]        res_pa,
    input logic               res_writable,
    input logic               res_priv,
    input cmd_st_e            state_q,
    input logic               cmd_slot_vld,
    input logic [ENTRIES-1:0] lock_eff,
    input logic [ENTRIES-1:0] vld_vec
);

    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_vld |=> res_vld);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_vld |=> !res_vld);

    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_pa == '0 && !res_writable && !res_priv));

    a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q == ST_LOAD);

    a_r12_demap_next: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_en && !wr_en) |=> state_q == ST_DEMAP);

    a_r12_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !dm_en) |=> state_q == ST_IDLE);

    a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !cmd_slot_vld && (&lock_eff)) |=> $stable(vld_vec));

endmodule

bind ctx_tlb ctx_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_vld       (lk_vld),
    .wr_en        (wr_en),
    .dm_en        (dm_en),
    .res_vld      (res_vld),
    .res_hit      (res_hit),
    .res_pa       (res_pa),
    .res_writable (res_writable),
    .res_priv     (res_priv),
    .state_q      (state_q),
    .cmd_slot_vld (cmd_slot_vld),
    .lock_eff     (lock_eff),
    .vld_vec      (vld_vec)
);

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_vld = 1'b0;
    logic [43:0] lk_va = '0;
    logic [1:0]  lk_asel = '0;
    logic [12:0] pri_ctx = 13'h005;
    logic [12:0] sec_ctx = 13'h123;
    logic        wr_en = 1'b0, wr_slot_vld = 1'b0;
    logic [5:0]  wr_slot = '0;
    logic [30:0] wr_vpn = '0;
    logic [12:0] wr_ctx = '0;
    logic [27:0] wr_ppn = '0;
    logic [1:0]  wr_size = '0;
    logic        wr_writable = 1'b0, wr_priv = 1'b0, wr_lock = 1'b0;
    logic        dm_en = 1'b0;
    logic [12:0] dm_ctx = '0;
    logic        res_vld, res_hit, res_writable, res_priv;
    logic [40:0] res_pa;

    always #10 clk = ~clk;

    ctx_tlb i_ctx_tlb (.*);

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // Bench model of the entries.
    logic        m_vld [64];
    logic        m_lock[64];
    logic [12:0] m_ctx [64];
    logic [43:0] m_va  [64];
    logic [40:0] m_pa  [64];
    int          m_size[64];
    logic        m_w   [64];
    logic        m_p   [64];
    int          m_ptr = 0;

    typedef struct {
        logic        hit;
        logic [40:0] pa;
        logic        w;
        logic        p;
        string       tag;
    } exp_t;
    exp_t exq[$];

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    function automatic void model_look(input logic [43:0] va, input logic [1:0] asel,
                                       output exp_t e);
        logic [12:0] c;
        logic [43:0] msk;
        c = (asel == 2'd0) ? pri_ctx : (asel == 2'd1) ? sec_ctx : 13'h0;
        e.hit = 0; e.pa = '0; e.w = 0; e.p = 0;
        for (int i = 0; i < 64; i++) begin
            msk = (44'h1 << (13 + 3 * m_size[i])) - 44'h1;
            if (!e.hit && m_vld[i] && m_ctx[i] == c && ((va ^ m_va[i]) & ~msk) == '0) begin
                e.hit = 1;
                e.pa  = (m_pa[i] & ~msk[40:0]) | (va[40:0] & msk[40:0]);
                e.w   = m_w[i];
                e.p   = m_p[i];
            end
        end
    endfunction

    function automatic void model_write(input bit sv, input int slot, input logic [43:0] va,
                                        input logic [12:0] c, input logic [40:0] pa, input int sz,
                                        input bit w, input bit p, input bit lk);
        int idx;
        idx = -1;
        if (sv) idx = slot;
        else begin
            for (int i = 0; i < 64; i++) begin
                int cnd;
                cnd = (m_ptr + i) % 64;
                if (idx < 0 && !(m_vld[cnd] && m_lock[cnd])) idx = cnd;
            end
            if (idx >= 0) m_ptr = (idx + 1) % 64;
        end
        if (idx >= 0) begin
            m_vld[idx] = 1; m_lock[idx] = lk; m_ctx[idx] = c;
            m_va[idx] = va & ~44'h1FFF; m_pa[idx] = pa & ~41'h1FFF;
            m_size[idx] = sz; m_w[idx] = w; m_p[idx] = p;
        end
    endfunction

    function automatic void model_demap(input logic [12:0] c);
        for (int i = 0; i < 64; i++) if (m_vld[i] && m_ctx[i] == c) m_vld[i] = 0;
    endfunction

    task automatic drive_wr(input bit sv, input int slot, input logic [43:0] va,
                            input logic [12:0] c, input logic [40:0] pa, input int sz,
                            input bit w, input bit p, input bit lk);
        wr_en = 1; wr_slot_vld = sv; wr_slot = 6'(slot); wr_vpn = va[43:13];
        wr_ctx = c; wr_ppn = pa[40:13]; wr_size = 2'(sz);
        wr_writable = w; wr_priv = p; wr_lock = lk;
    endtask

    task automatic do_write(input bit sv, input int slot, input logic [43:0] va,
                            input logic [12:0] c, input logic [40:0] pa, input int sz,
                            input bit w, input bit p, input bit lk);
        @(negedge clk); lk_vld = 0; dm_en = 0;
        drive_wr(sv, slot, va, c, pa, sz, w, p, lk);
        @(negedge clk); wr_en = 0;
        @(negedge clk);
        model_write(sv, slot, va, c, pa, sz, w, p, lk);
    endtask

    task automatic do_demap(input logic [12:0] c);
        @(negedge clk); lk_vld = 0; wr_en = 0; dm_en = 1; dm_ctx = c;
        @(negedge clk); dm_en = 0;
        @(negedge clk);
        model_demap(c);
    endtask

    task automatic look(input logic [43:0] va, input logic [1:0] asel, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = 0; dm_en = 0;
        lk_vld = 1; lk_va = va; lk_asel = asel;
        model_look(va, asel, e);
        e.tag = tag;
        exq.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk); lk_vld = 0; wr_en = 0; dm_en = 0;
    endtask

    // Monitor: pops one expected item per result.
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            if (exq.size() == 0) begin
                check(0, "R2 unexpected result", "res_vld=1", "res_vld=0");
            end else begin
                exp_t e;
                e = exq.pop_front();
                check(res_hit == e.hit && res_pa == e.pa && res_writable == e.w && res_priv == e.p,
                      e.tag,
                      $sformatf("hit=%0b pa=%h w=%0b p=%0b", res_hit, res_pa, res_writable, res_priv),
                      $sformatf("hit=%0b pa=%h w=%0b p=%0b", e.hit, e.pa, e.w, e.p));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_vld[i] = 0; m_lock[i] = 0; m_ctx[i] = 0; m_va[i] = 0;
            m_pa[i] = 0; m_size[i] = 0; m_w[i] = 0; m_p[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(res_vld == 0, "R1 reset res_vld", $sformatf("%0b", res_vld), "0");
        look(44'h000_1234_5678, 2'd0, "R1 empty after reset");

        // R3: 8 KB page
        do_write(1, 3, 44'hABC_DEF0_2000, 13'h005, 41'h1_2345_6000, 0, 1, 0, 0);
        look(44'hABC_DEF0_3ABC, 2'd0, "R3 8K hit");
        look(44'hABC_DEF0_4000, 2'd0, "R3 8K neighbour miss");
        idle();

        // R4: larger pages, low bits from lookup address
        do_write(1, 4, 44'h123_4540_0000, 13'h005, 41'h0_8000_0000, 3, 0, 0, 0);
        do_write(1, 5, 44'h000_9999_1234, 13'h005, 41'h0_5555_F123, 1, 1, 0, 0);
        do_write(1, 6, 44'h0F0_0008_0000, 13'h005, 41'h1_0000_0000, 2, 0, 1, 0);
        look(44'h123_457F_FFF8, 2'd0, "R4 4M hit");
        look(44'h123_4580_0000, 2'd0, "R4 4M next page miss");
        look(44'h000_9999_ABCD, 2'd0, "R4 64K hit masked");
        look(44'h000_999A_0000, 2'd0, "R4 64K next page miss");
        look(44'h0F0_000F_FFF0, 2'd0, "R7 R4 512K hit flags");
        idle();

        // R5/R6: contexts and address-space classes
        do_write(1, 7, 44'hABC_DEF0_2000, 13'h123, 41'h0_7777_0000, 0, 0, 1, 0);
        do_write(1, 8, 44'h000_0000_E000, 13'h000, 41'h1_F000_0000, 0, 1, 1, 0);
        look(44'hABC_DEF0_2010, 2'd0, "R5 primary context entry");
        look(44'hABC_DEF0_2010, 2'd1, "R5 secondary context entry");
        look(44'h123_4540_0000, 2'd1, "R5 wrong context miss");
        look(44'h000_0000_E004, 2'd2, "R6 nucleus class 2");
        look(44'h000_0000_E008, 2'd3, "R6 nucleus class 3");
        look(44'h000_0000_E00C, 2'd0, "R6 primary not zero miss");
        idle();
        pri_ctx = 13'h000;
        look(44'h000_0000_E00C, 2'd0, "R6 primary set to zero");
        idle();
        pri_ctx = 13'h005;

        // R14: multiple hits, R8: explicit overwrite
        do_write(1, 10, 44'h222_2222_0000, 13'h005, 41'h0_0AAA_0000, 0, 0, 0, 0);
        do_write(1, 9,  44'h222_2222_0000, 13'h005, 41'h0_0BBB_0000, 0, 1, 0, 0);
        look(44'h222_2222_0100, 2'd0, "R14 lowest slot wins");
        idle();
        do_write(1, 9, 44'h333_0000_0000, 13'h005, 41'h0_0CCC_0000, 0, 0, 0, 0);
        look(44'h222_2222_0100, 2'd0, "R8 overwritten slot gone");
        look(44'h333_0000_0010, 2'd0, "R8 new content");
        idle();

        // R9: round-robin skipping locked
        do_write(1, 1, 44'h400_0000_0000, 13'h005, 41'h0_1111_0000, 0, 0, 0, 1);
        do_write(0, 0, 44'h401_0000_0000, 13'h005, 41'h0_2222_0000, 0, 0, 0, 0);
        do_write(0, 0, 44'h402_0000_0000, 13'h005, 41'h0_3333_0000, 0, 0, 0, 0);
        do_write(0, 0, 44'h403_0000_0000, 13'h005, 41'h0_4444_0000, 0, 0, 0, 0);
        look(44'h400_0000_0000, 2'd0, "R9 locked kept");
        look(44'h401_0000_0000, 2'd0, "R9 first victim");
        look(44'h402_0000_0000, 2'd0, "R9 skipped locked");
        look(44'h403_0000_0000, 2'd0, "R9 third victim");
        look(44'hABC_DEF0_2000, 2'd0, "R9 slot3 replaced");
        idle();
        do_write(1, 2, 44'h404_0000_0000, 13'h005, 41'h0_5555_0000, 0, 0, 0, 0);
        look(44'h402_0000_0000, 2'd0, "R9 victim position slot2");
        idle();

        // R11: demap by context
        do_demap(13'h123);
        look(44'hABC_DEF0_2000, 2'd1, "R11 demapped context");
        look(44'h123_4540_0000, 2'd0, "R11 other context kept");
        idle();
        do_demap(13'h005);
        look(44'h400_0000_0000, 2'd0, "R11 locked demapped");
        look(44'h000_0000_E000, 2'd2, "R11 context zero kept");
        idle();

        // R12: lookup in the cycle a command is applied
        do_write(1, 20, 44'h500_0000_0000, 13'h005, 41'h0_6666_0000, 0, 1, 1, 0);
        @(negedge clk); lk_vld = 0; dm_en = 1; dm_ctx = 13'h005;
        look(44'h500_0000_0000, 2'd0, "R12 demap apply cycle old");
        model_demap(13'h005);
        look(44'h500_0000_0000, 2'd0, "R12 demap after");
        idle();
        @(negedge clk);
        drive_wr(1, 21, 44'h510_0000_0000, 13'h005, 41'h0_7070_0000, 0, 0, 0, 0);
        look(44'h510_0000_0000, 2'd0, "R12 write apply cycle old");
        model_write(1, 21, 44'h510_0000_0000, 13'h005, 41'h0_7070_0000, 0, 0, 0, 0);
        look(44'h510_0000_0000, 2'd0, "R12 write after");
        idle();

        // R13: write and demap in one cycle
        @(negedge clk);
        drive_wr(1, 22, 44'h520_0000_0000, 13'h005, 41'h0_7272_0000, 0, 1, 0, 0);
        dm_en = 1; dm_ctx = 13'h005;
        @(negedge clk); wr_en = 0; dm_en = 0;
        @(negedge clk);
        model_write(1, 22, 44'h520_0000_0000, 13'h005, 41'h0_7272_0000, 0, 1, 0, 0);
        look(44'h520_0000_0000, 2'd0, "R13 write taken");
        look(44'h510_0000_0000, 2'd0, "R13 demap ignored");
        idle();

        // R10: every entry locked, round-robin write dropped
        for (int i = 0; i < 64; i++)
            do_write(1, i, 44'h600_0000_0000 + (44'(i) << 13), 13'h077,
                     41'h0_0100_0000 + (41'(i) << 13), 0, 0, 0, 1);
        do_write(0, 0, 44'h6FF_0000_0000, 13'h077, 41'h0_0F00_0000, 0, 1, 1, 0);
        pri_ctx = 13'h077;
        look(44'h6FF_0000_0000, 2'd0, "R10 dropped write");
        look(44'h600_0000_A000, 2'd0, "R10 locked entry intact");
        idle();
        idle();

        check(exq.size() == 0, "R2 all results returned", $sformatf("%0d", exq.size()), "0");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule